// File: doc/BRIEF.md
# Frame-Tick Timer and Clock Bank

This block holds a set of counters that advance once per video frame. A single-cycle `tick` input marks each frame. On every tick a 24-bit frame clock counts up and the first countdown timer counts down. This is the primary stage, and it always runs. A secondary stage counts down four more timers and a keyboard debounce counter. The secondary stage is skipped for any tick that arrives while the `critical` input is high. Software loads and reads every counter through a small register port that has a synchronous write and a combinational read.

Each countdown timer is 16 bits wide and is idle when it holds zero. Two of the timers end in a one-cycle callback request. The other three end in a sticky flag, which stays set until its timer is loaded with a nonzero value. The callback requests and the flags come out on ports for the surrounding interrupt logic to use.

Register map (the data bus is 16 bits wide; narrow registers use its low bits):
- Address 0: clock bits 23:16.
- Address 1: clock bits 15:8.
- Address 2: clock bits 7:0.
- Addresses 3 to 7: timers 1 to 5.
- Address 8: debounce counter (8 bits).
- Address 9: flags of timers 3, 4 and 5 in bits 0, 1 and 2.
- Addresses 10 to 15: read as zero.

Top module: `frame_timer_bank`

## Requirements
- R1: After reset, every register reads zero, `cbReq` is 0 and `timerFlag` is 0.
- R2: Each tick adds one to the 24-bit clock, and the clock wraps from 0xFFFFFF to 0. Address 0 reads the most significant byte, address 1 the middle byte and address 2 the least significant byte.
- R3: Timer 1 (address 3) decrements on every tick, whatever the level of `critical`. On the tick that takes it from 1 to 0, `cbReq[0]` is high for exactly the one cycle after that clock edge.
- R4: Timer 2 (address 4) decrements in the secondary stage. On its step from 1 to 0, `cbReq[1]` pulses for one cycle, with the same timing as in R3.
- R5: Timers 3, 4 and 5 (addresses 5 to 7) decrement in the secondary stage. On its step from 1 to 0, each timer sets `timerFlag[0]`, `[1]` or `[2]` respectively. A flag then stays set, and it also reads back in bits 2:0 of address 9.
- R6: A timer that holds zero does not change on a tick and raises no callback and no flag.
- R7: Writing a nonzero value to timer 3, 4 or 5 clears that timer's flag. Writing zero leaves the flag unchanged.
- R8: The debounce counter (address 8) decrements in the secondary stage while it is nonzero, and stays at zero once it gets there.
- R9: A tick with `critical` high leaves timers 2 to 5 and the debounce counter unchanged, while the clock and timer 1 still advance.
- R10: A write in the same cycle as a tick sets the written register to the written value and no tick step is applied to it. Writing any clock byte stops the clock from incrementing in that cycle. All other registers advance as usual.
- R11: Reads of addresses 10 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle frame tick |
| critical | input | 1 | When high, the secondary stage is skipped for this tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 16 | Read data (combinational) |
| cbReq | output | 2 | Callback request pulses for timers 1 and 2 |
| timerFlag | output | 3 | Sticky expiry flags for timers 3 to 5 |

## Verification
A timer that counts at the wrong moment becomes visible in two ways. One is a callback or flag that arrives one tick early or late. The other is a count that reads back off by one on the very next register read after the tick. Because of this, the timers are swept over several load values, and each timer is checked on every tick and not only at the end. A stage-selection fault shows up on the first tick taken under `critical`, either as a secondary-stage counter that has moved or as a frozen clock. A byte-ordering or wrap fault in the clock shows up on the first read after a carry across a byte boundary.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  localparam int ADDR_W      = 4;
  localparam int NUM_TMR     = 5;
  localparam int N_CB        = 2;
  localparam int N_FLAG      = NUM_TMR - N_CB;
  localparam int STAGE1_TMRS = 1;
  localparam int CLK_BYTES   = 3;
  localparam int ADDR_CLK0   = 0;
  localparam int ADDR_TMR0   = ADDR_CLK0 + CLK_BYTES;
  localparam int ADDR_DEB    = ADDR_TMR0 + NUM_TMR;
  localparam int ADDR_FLG    = ADDR_DEB + 1;

  typedef struct packed {
    logic                 stage1;
    logic                 stage2;
    logic [CLK_BYTES-1:0] ldClk;
    logic [NUM_TMR-1:0]   ldTmr;
    logic                 ldDeb;
  } strobes_t;
endpackage

// File: rtl/ftb_ctrl.sv
module ftb_ctrl
  import ftb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              critical,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output strobes_t          ctl
);
  always_comb begin
    ctl.stage1 = tick;
    ctl.stage2 = tick && !critical;
    for (int b = 0; b < CLK_BYTES; b++)
      ctl.ldClk[b] = wrEn && (wrAddr == ADDR_W'(ADDR_CLK0 + b));
    for (int i = 0; i < NUM_TMR; i++)
      ctl.ldTmr[i] = wrEn && (wrAddr == ADDR_W'(ADDR_TMR0 + i));
    ctl.ldDeb = wrEn && (wrAddr == ADDR_W'(ADDR_DEB));
  end

  // R10
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ldClk, ctl.ldTmr, ctl.ldDeb}));
  // R9
  stage_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stage2 |-> ctl.stage1);
endmodule

// File: rtl/ftb_datapath.sv
module ftb_datapath
  import ftb_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int DEB_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          ctl,
  input  logic [TMR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [TMR_W-1:0]  rdData,
  output logic [N_CB-1:0]   cbReq,
  output logic [N_FLAG-1:0] timerFlag
);
  localparam int CLK_W = CLK_BYTES * 8;

  logic [CLK_W-1:0] clkCnt;
  logic [TMR_W-1:0] tmr [NUM_TMR];
  logic [DEB_W-1:0] deb;
  logic [NUM_TMR-1:0] advTmr;
  logic [NUM_TMR-1:0] hit;

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    if (gi < STAGE1_TMRS) begin : g_s1
      assign advTmr[gi] = ctl.stage1;
    end else begin : g_s2
      assign advTmr[gi] = ctl.stage2;
    end
    assign hit[gi] = advTmr[gi] && !ctl.ldTmr[gi] && (tmr[gi] == TMR_W'(1));

    // R6
    idle_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tmr[gi] == '0) && !ctl.ldTmr[gi] |=> (tmr[gi] == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCnt <= '0;
    end else if (|ctl.ldClk) begin
      for (int b = 0; b < CLK_BYTES; b++)
        if (ctl.ldClk[b]) clkCnt[(CLK_BYTES-1-b)*8 +: 8] <= wrData[7:0];
    end else if (ctl.stage1) begin
      clkCnt <= clkCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TMR; i++) tmr[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (ctl.ldTmr[i]) tmr[i] <= wrData;
        else if (advTmr[i] && tmr[i] != '0) tmr[i] <= tmr[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deb <= '0;
    end else if (ctl.ldDeb) begin
      deb <= wrData[DEB_W-1:0];
    end else if (ctl.stage2 && deb != '0) begin
      deb <= deb - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbReq     <= '0;
      timerFlag <= '0;
    end else begin
      cbReq <= hit[N_CB-1:0];
      for (int j = 0; j < N_FLAG; j++) begin
        if (ctl.ldTmr[N_CB+j] && wrData != '0) timerFlag[j] <= 1'b0;
        else if (hit[N_CB+j]) timerFlag[j] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < CLK_BYTES; b++)
      if (rdAddr == ADDR_W'(ADDR_CLK0 + b))
        rdData = TMR_W'(clkCnt[(CLK_BYTES-1-b)*8 +: 8]);
    for (int i = 0; i < NUM_TMR; i++)
      if (rdAddr == ADDR_W'(ADDR_TMR0 + i)) rdData = tmr[i];
    if (rdAddr == ADDR_W'(ADDR_DEB)) rdData = TMR_W'(deb);
    if (rdAddr == ADDR_W'(ADDR_FLG)) rdData = TMR_W'(timerFlag);
  end

  // R2
  clock_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stage1 && (ctl.ldClk == '0) |=> clkCnt == $past(clkCnt) + 1'b1);
  // R3
  cb_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cbReq[0] |=> !cbReq[0]);
  // R4
  cb2_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cbReq[1] |=> !cbReq[1]);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerFlag[0] && !(ctl.ldTmr[N_CB] && wrData != '0) |=> timerFlag[0]);
  // R8
  deb_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deb == '0) && !ctl.ldDeb |=> (deb == '0));
  // R9
  crit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stage1 && !ctl.stage2 && !ctl.ldTmr[1] |=> $stable(tmr[1]));
endmodule

// File: rtl/frame_timer_bank.sv
module frame_timer_bank
  import ftb_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int DEB_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              critical,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [TMR_W-1:0]  rdData,
  output logic [N_CB-1:0]   cbReq,
  output logic [N_FLAG-1:0] timerFlag
);
  strobes_t ctl;

  ftb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .critical(critical),
    .wrEn(wrEn), .wrAddr(wrAddr), .ctl(ctl)
  );

  ftb_datapath #(.TMR_W(TMR_W), .DEB_W(DEB_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cbReq(cbReq), .timerFlag(timerFlag)
  );
endmodule

// File: tb/tb_frame_timer_bank.sv
module tb_frame_timer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        critical = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [1:0]  cbReq;
  logic [2:0]  timerFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [1:0] lastCb;
  logic [2:0] expFlag;

  frame_timer_bank dut (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(string req, int a, logic [15:0] exp);
    rdAddr = 4'(a);
    #1;
    check(req, rdData, exp);
  endtask

  // one cycle: optional write and optional tick together
  task automatic cyc(bit doTick, bit crit, bit doWr, int a, logic [15:0] d);
    @(negedge clk);
    tick = doTick; critical = crit; wrEn = doWr; wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    tick = 1'b0; critical = 1'b0; wrEn = 1'b0;
    lastCb = cbReq;
  endtask

  task automatic wr(int a, logic [15:0] d);
    cyc(1'b0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 and R11: everything zero after reset
    for (int a = 0; a < 16; a++) rd(a < 10 ? "R1" : "R11", a, 16'h0);
    check("R1", {cbReq, timerFlag}, 0);

    // R2: byte order, counting, and R9 primary stage runs under critical
    wr(0, 16'h12); wr(1, 16'h34); wr(2, 16'hFE);
    rd("R2", 0, 16'h12); rd("R2", 1, 16'h34); rd("R2", 2, 16'hFE);
    for (int k = 0; k < 5; k++) cyc(1'b1, k[0], 1'b0, 0, 0);
    rd("R2", 0, 16'h12); rd("R2", 1, 16'h35); rd("R2", 2, 16'h03);
    // R2: wrap
    wr(0, 16'hFF); wr(1, 16'hFF); wr(2, 16'hFF);
    cyc(1'b1, 1'b0, 1'b0, 0, 0);
    for (int a = 0; a < 3; a++) rd("R2", a, 16'h0);

    // R3 R4 R5 R6: sweep every timer over load values
    expFlag = '0;
    for (int t = 0; t < 5; t++) begin
      for (int n = 1; n <= 5; n++) begin
        wr(3 + t, 16'(n));
        if (t >= 2 && n > 1) begin
          expFlag[t-2] = 1'b0; // R7: nonzero load clears
        end
        check("R7", timerFlag, expFlag);
        for (int k = 1; k <= n; k++) begin
          cyc(1'b1, 1'b0, 1'b0, 0, 0);
          rd(t == 0 ? "R3" : t == 1 ? "R4" : "R5", 3 + t, 16'(n - k));
          check(t == 0 ? "R3" : "R4", lastCb,
                (k == n && t < 2) ? (2'b01 << t) : 2'b00);
          if (k == n && t >= 2) expFlag[t-2] = 1'b1;
          check("R5", timerFlag, expFlag);
        end
        // R6: idle timer stays zero, no new event
        cyc(1'b1, 1'b0, 1'b0, 0, 0);
        rd("R6", 3 + t, 16'h0);
        check("R6", lastCb, 2'b00);
        rd("R5", 9, 16'(expFlag));
      end
    end
    // R7: zero load keeps the flag, nonzero load clears it
    wr(5, 16'h0);
    check("R7", timerFlag, expFlag);
    wr(6, 16'h7);
    expFlag[1] = 1'b0;
    check("R7", timerFlag, expFlag);

    // R9: critical skips the secondary stage
    for (int t = 0; t < 5; t++) wr(3 + t, 16'h3);
    wr(8, 16'h2);
    expFlag = 3'b000;
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    rd("R9", 3, 16'h1);
    for (int t = 1; t < 5; t++) rd("R9", 3 + t, 16'h3);
    rd("R9", 8, 16'h2);
    cyc(1'b1, 1'b0, 1'b0, 0, 0);
    check("R3", lastCb, 2'b01);
    rd("R3", 3, 16'h0);
    for (int t = 1; t < 5; t++) rd("R9", 3 + t, 16'h2);
    rd("R8", 8, 16'h1);
    check("R9", timerFlag, expFlag);

    // R8: debounce counts down and floors at zero
    wr(8, 16'h3);
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 1'b0, 1'b0, 0, 0);
      rd("R8", 8, 16'(k < 3 ? 3 - k : 0));
    end

    // R10: write in a tick cycle wins for that register only
    wr(3, 16'h4); wr(4, 16'h5); wr(0, 16'h0); wr(1, 16'h0); wr(2, 16'h10);
    cyc(1'b1, 1'b0, 1'b1, 4, 16'h9);
    rd("R10", 4, 16'h9);
    rd("R10", 3, 16'h3);
    rd("R10", 2, 16'h11);
    cyc(1'b1, 1'b0, 1'b1, 2, 16'h40);
    rd("R10", 2, 16'h40);
    rd("R10", 3, 16'h2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule